// File: doc/BRIEF.md
# USB Frame Tick Generator with SOF Interpolation

This block produces the once-per-frame update event and the 11-bit frame number for a USB controller. It works in one of two modes.

In peripheral mode it follows the host's start-of-frame packets. A valid SOF strobe loads the frame number carried by the packet and restarts an internal frame timer. A corrupted SOF still marks a frame boundary, so it advances the frame number by one. If no SOF arrives by the end of the frame period plus a small tolerance, the timer supplies the update itself. Later filled-in updates stay on the nominal frame grid.

In host mode the block free-runs on its timer and advances the frame number once per period. The update pulse is shown only when at least one of two port-active inputs is high at the moment of the advance.

The control is a three-state machine:
- `ST_UNSYNC`: peripheral mode, not yet locked.
- `ST_TRACK`: peripheral mode, locked to the host's frames.
- `ST_HOST`: free-running host mode.

Its transitions are:
- UNSYNC→TRACK on the first valid SOF.
- UNSYNC/TRACK→HOST when host mode is selected.
- HOST→UNSYNC when host mode is deselected.
- Any unknown encoding returns to UNSYNC.

Top module: `usb_frame_tick`

## Requirements
- R1: During and right after reset, `frame_num` is 0 and `frame_tick` is 0. The machine starts in the unsynchronized peripheral state.
- R2: In peripheral mode with `host_mode` low, a cycle with `sof_valid` high gives `frame_tick`=1 and `frame_num`=`sof_frame` in the following cycle. It also restarts the frame timer and moves the machine to tracking.
- R3: While tracking, `sof_bad` without `sof_valid` gives `frame_tick`=1 and `frame_num` = previous + 1 modulo 2048 in the following cycle, so 2047 wraps to 0. It also restarts the timer, so the next filled-in update comes PERIOD_CYC+TOL_CYC cycles later.
- R4: While tracking with no SOF input, an update (`frame_num` + 1, `frame_tick`=1) comes PERIOD_CYC+TOL_CYC cycles after the last update that reloaded the timer. Each further missing frame then gives an update every PERIOD_CYC cycles.
- R5: When `sof_valid` and `sof_bad` are high in the same cycle, the valid packet wins: the frame number is loaded, not incremented.
- R6: Before the first valid SOF in peripheral mode, no `frame_tick` is produced, `sof_bad` has no effect and `frame_num` holds.
- R7: In host mode, `frame_num` advances by 1 modulo 2048 every PERIOD_CYC cycles. The first advance comes PERIOD_CYC cycles after the cycle in which the machine entered host mode.
- R8: In host mode, `frame_tick` is 1 in the cycle the frame number advances exactly when `port0_act` or `port1_act` was 1 at that advance. Otherwise the number still advances with no tick.
- R9: In host mode, `sof_valid`, `sof_frame` and `sof_bad` have no effect on `frame_num`.
- R10: Clearing `host_mode` returns the machine to the unsynchronized state. It then holds `frame_num` with no ticks until a valid SOF, which is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host (free-running), 0 = peripheral (SOF-following) |
| port0_act | input | 1 | Port 0 active; gates the host-mode tick |
| port1_act | input | 1 | Port 1 active; gates the host-mode tick |
| sof_valid | input | 1 | Strobe: a valid SOF packet was received |
| sof_frame | input | 11 | Frame number carried by the valid SOF |
| sof_bad | input | 1 | Strobe: an SOF packet was received corrupted |
| frame_num | output | 11 | Current frame number |
| frame_tick | output | 1 | One-cycle frame-update event, aligned with the frame number change |

## Verification
The hardest condition to reach from the ports is the filled-in update that follows another filled-in update. It only occurs after a full period plus tolerance passes with no SOF, and then another whole period passes in silence. The stimulus therefore locks the block with one valid SOF and stays silent across two frame deadlines.

The bench runs with a short period to keep the run brief. A corrupted SOF is sent with the counter at 2047 to exercise the wrap to 0. A valid and a corrupted SOF are then sent in the same cycle to test the priority rule. The host-mode part feeds SOF strobes that must be ignored, and it moves the port-active bits between updates.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;

    localparam int unsigned FN_W = 11;

    typedef enum logic [1:0] {
        ST_UNSYNC = 2'd0,
        ST_TRACK  = 2'd1,
        ST_HOST   = 2'd2
    } ft_state_e;

    typedef enum logic [1:0] {
        FN_HOLD = 2'd0,
        FN_LOAD = 2'd1,
        FN_INC  = 2'd2
    } fn_op_e;

endpackage

// File: rtl/ft_interval_timer.sv
module ft_interval_timer #(
    parameter int unsigned PERIOD = 60000,
    parameter int unsigned TOL    = 4,
    parameter int unsigned CW     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic reload_tol,
    output logic host_due,
    output logic track_due
);
    localparam logic [CW-1:0] HOST_LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] TRACK_LAST = CW'(PERIOD + TOL - 1);
    localparam logic [CW-1:0] TOL_START  = CW'(TOL);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload_tol ? TOL_START : '0;
        end else if (cnt_q != TRACK_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign host_due  = (cnt_q == HOST_LAST);
    assign track_due = (cnt_q == TRACK_LAST);

    // R4: the interval counter never runs past the tracking deadline
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TRACK_LAST);

    // R4: a restart places the counter at its reload point
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == ($past(reload_tol) ? TOL_START : '0)));

endmodule

// File: rtl/ft_frame_reg.sv
module ft_frame_reg
    import usb_ft_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  fn_op_e          op,
    input  logic [FN_W-1:0] load_val,
    output logic [FN_W-1:0] fn_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q <= '0;
        end else begin
            unique case (op)
                FN_LOAD: fn_q <= load_val;
                FN_INC:  fn_q <= fn_q + 1'b1;
                default: fn_q <= fn_q;
            endcase
        end
    end

    // R7: an increment advances the number by one, wrapping at 2048
    p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FN_INC) |=> (fn_q == FN_W'($past(fn_q) + 1)));

    // R9: with no operation the number is held
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == FN_HOLD) |=> $stable(fn_q));

endmodule

// File: rtl/ft_sync_fsm.sv
module ft_sync_fsm
    import usb_ft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_mode,
    input  logic      port0_act,
    input  logic      port1_act,
    input  logic      sof_valid,
    input  logic      sof_bad,
    input  logic      host_due,
    input  logic      track_due,
    output logic      restart,
    output logic      reload_tol,
    output fn_op_e    fn_op,
    output logic      tick_q,
    output ft_state_e st_q
);
    ft_state_e st_d;
    logic      tick_d;

    always_comb begin
        st_d       = st_q;
        fn_op      = FN_HOLD;
        tick_d     = 1'b0;
        restart    = 1'b0;
        reload_tol = 1'b0;
        unique case (st_q)
            ST_UNSYNC: begin
                if (host_mode) begin
                    st_d    = ST_HOST;
                    restart = 1'b1;
                end else if (sof_valid) begin
                    st_d    = ST_TRACK;
                    fn_op   = FN_LOAD;
                    tick_d  = 1'b1;
                    restart = 1'b1;
                end
            end
            ST_TRACK: begin
                if (host_mode) begin
                    st_d    = ST_HOST;
                    restart = 1'b1;
                end else if (sof_valid) begin
                    fn_op   = FN_LOAD;
                    tick_d  = 1'b1;
                    restart = 1'b1;
                end else if (sof_bad) begin
                    fn_op   = FN_INC;
                    tick_d  = 1'b1;
                    restart = 1'b1;
                end else if (track_due) begin
                    fn_op      = FN_INC;
                    tick_d     = 1'b1;
                    restart    = 1'b1;
                    reload_tol = 1'b1;
                end
            end
            ST_HOST: begin
                if (!host_mode) begin
                    st_d    = ST_UNSYNC;
                    restart = 1'b1;
                end else if (host_due) begin
                    fn_op   = FN_INC;
                    tick_d  = port0_act | port1_act;
                    restart = 1'b1;
                end
            end
            default: begin
                st_d = ST_UNSYNC;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_UNSYNC;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    // R6: an unsynchronized machine without a valid SOF stays silent
    p_unsync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNSYNC && !sof_valid) |=> !tick_q);

    // R8: a host-mode advance with both ports idle raises no tick
    p_host_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOST && host_mode && host_due && !port0_act && !port1_act)
        |=> !tick_q);

    // R10: dropping host mode lands in the unsynchronized state
    p_leave_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOST && !host_mode) |=> (st_q == ST_UNSYNC));

endmodule

// File: rtl/usb_frame_tick.sv
module usb_frame_tick
    import usb_ft_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 60000,
    parameter int unsigned TOL_CYC    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_mode,
    input  logic            port0_act,
    input  logic            port1_act,
    input  logic            sof_valid,
    input  logic [FN_W-1:0] sof_frame,
    input  logic            sof_bad,
    output logic [FN_W-1:0] frame_num,
    output logic            frame_tick
);
    localparam int unsigned CW = $clog2(PERIOD_CYC + TOL_CYC);

    logic      restart;
    logic      reload_tol;
    logic      host_due;
    logic      track_due;
    fn_op_e    fn_op;
    ft_state_e st;

    ft_interval_timer #(
        .PERIOD (PERIOD_CYC),
        .TOL    (TOL_CYC),
        .CW     (CW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .reload_tol (reload_tol),
        .host_due   (host_due),
        .track_due  (track_due)
    );

    ft_sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_mode  (host_mode),
        .port0_act  (port0_act),
        .port1_act  (port1_act),
        .sof_valid  (sof_valid),
        .sof_bad    (sof_bad),
        .host_due   (host_due),
        .track_due  (track_due),
        .restart    (restart),
        .reload_tol (reload_tol),
        .fn_op      (fn_op),
        .tick_q     (frame_tick),
        .st_q       (st)
    );

    ft_frame_reg u_fn (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (fn_op),
        .load_val (sof_frame),
        .fn_q     (frame_num)
    );

    // R2 and R5: an accepted valid SOF loads its number and ticks, even beside a bad one
    p_sof_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HOST && !host_mode && sof_valid)
        |=> (frame_tick && frame_num == $past(sof_frame)));

endmodule

// File: tb/usb_frame_tick_bench.sv
module usb_frame_tick_bench;
    localparam int P = 100;
    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode = 1'b0;
    logic        port0_act = 1'b0;
    logic        port1_act = 1'b0;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        sof_bad = 1'b0;
    logic [10:0] frame_num;
    logic        frame_tick;

    usb_frame_tick #(.PERIOD_CYC(P), .TOL_CYC(T)) u_usb_frame_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_mode  (host_mode),
        .port0_act  (port0_act),
        .port1_act  (port1_act),
        .sof_valid  (sof_valid),
        .sof_frame  (sof_frame),
        .sof_bad    (sof_bad),
        .frame_num  (frame_num),
        .frame_tick (frame_tick)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    fn;
        int    at;
        string tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_tick(input int fn, input int at, input string tag);
        exp_t e;
        e.fn = fn; e.at = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // driver: called at a negedge, tick expected after the next posedge
    task automatic send_sof(input int fn, input bit bad, input string tag);
        sof_valid = 1'b1;
        sof_bad   = bad;
        sof_frame = 11'(fn);
        expect_tick(fn, cyc + 1, tag);
        @(negedge clk);
        sof_valid = 1'b0;
        sof_bad   = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                exp_t m;
                m = sb.pop_front();
                chk(1'b0, {m.tag, " missing tick"}, 0, m.at);
            end
            if (frame_tick) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6/R8/R10 unexpected tick", int'(frame_num), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.at == cyc, {e.tag, " tick cycle"}, cyc, e.at);
                    chk(int'(frame_num) == e.fn, {e.tag, " frame number"}, int'(frame_num), e.fn);
                end
            end
        end
    end

    initial begin
        int t;
        int h;
        repeat (3) @(negedge clk);
        chk(frame_num == 11'd0, "R1 reset frame_num", int'(frame_num), 0);
        chk(frame_tick == 1'b0, "R1 reset tick", int'(frame_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_num == 11'd0 && !frame_tick, "R1 after reset", int'(frame_num), 0);

        // R6: unsynchronized, corrupted SOF ignored
        sof_bad = 1'b1;
        @(negedge clk);
        sof_bad = 1'b0;
        wait_to(cyc + 3 * P);
        chk(frame_num == 11'd0, "R6 hold while unsynced", int'(frame_num), 0);

        // R2 lock, then R4 two filled-in updates
        t = cyc;
        send_sof(5, 1'b0, "R2");
        expect_tick(6, t + 1 + P + T, "R4 first fill");
        expect_tick(7, t + 1 + 2 * P + T, "R4 second fill");
        wait_to(t + 2 * P + T + 21);
        t = cyc;
        send_sof(2047, 1'b0, "R2");
        wait_to(t + 10);
        // R3: corrupted SOF at 2047 wraps to 0, timer restarts
        t = cyc;
        sof_bad = 1'b1;
        expect_tick(0, t + 1, "R3 wrap");
        expect_tick(1, t + 1 + P + T, "R3 restart");
        @(negedge clk);
        sof_bad = 1'b0;
        wait_to(t + P + T + 11);
        // R5: valid wins over corrupted
        send_sof(300, 1'b1, "R5");
        wait_to(cyc + 8);

        // host mode
        h = cyc;
        host_mode = 1'b1;
        wait_to(h + 50);
        send_sof(99, 1'b1, "R9");
        void'(sb.pop_back());
        wait_to(h + 100);
        chk(frame_num == 11'd300, "R9 SOF ignored in host", int'(frame_num), 300);
        wait_to(h + 101);
        chk(frame_num == 11'd301, "R7 host advance", int'(frame_num), 301);
        chk(frame_tick == 1'b0, "R8 no tick ports idle", int'(frame_tick), 0);
        wait_to(h + 150);
        port1_act = 1'b1;
        expect_tick(302, h + 1 + 2 * P, "R8 port1");
        wait_to(h + 250);
        port1_act = 1'b0;
        port0_act = 1'b1;
        expect_tick(303, h + 1 + 3 * P, "R8 port0");
        wait_to(h + 320);
        port0_act = 1'b0;
        host_mode = 1'b0;

        // R10: back to unsynchronized
        wait_to(h + 650);
        chk(frame_num == 11'd303, "R10 hold after host", int'(frame_num), 303);
        send_sof(10, 1'b0, "R10 resync");
        wait_to(cyc + 5);
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        chk(1'b0, "watchdog", cyc, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule